// File: doc/BRIEF.md
# Handheld System Bus Address Decoder

This block sits between a 32-bit processor bus and the memories and peripherals of a handheld system. Each cycle it accepts at most one access of byte, halfword or word size, decides which of nine regions owns the address, and drives a one-hot select to that region. The region sees an address whose low bits are masked to suit the access size. The block decides for each access whether to forward it, drop it quietly, or report it as undefined. Read data from the chosen region is registered and comes back one cycle after the request.

The cartridge backup store has an 8-bit data path, so the block adapts wider accesses to it. A wide read copies the single fetched byte into every lane that the access covers. A wide write picks the byte lane named by the low address bits and sends only that byte. Some write patterns are dropped without complaint: writes to the general-purpose pins in cartridge space, byte writes to the three video-related memories, and one reserved byte address above the I/O window. Any other access that has no owner returns zero. It also raises a one-cycle indication and sets a sticky flag, which software clears through a dedicated input.

Top module: `hbus_decoder`

## Requirements
- R1: A forwarded access drives exactly one bit of `rgn_sel`: bit 0 boot ROM 0x0000_0000..0x0000_3FFF, bit 1 external RAM 0x02xx_xxxx, bit 2 internal RAM 0x03xx_xxxx, bit 3 I/O 0x0400_0000..0x0400_03FE, bit 4 palette 0x05xx_xxxx, bit 5 video RAM 0x06xx_xxxx, bit 6 object memory 0x07xx_xxxx, bit 7 cartridge ROM 0x0800_0000..0x0DFF_FFFF, bit 8 backup 0x0E00_0000..0x0FFF_FFFF. The decode uses the unmasked request address. `rgn_we` follows `req_write` and `rgn_size` follows `req_size`.
- R2: For size 2'b10 (word) `rgn_addr` has bits [1:0] cleared. For 2'b01 (half) bit 0 is cleared. For 2'b00 (byte) the address passes unchanged. This applies to all regions except backup.
- R3: `rsp_valid` and `rsp_rdata` appear in the cycle after the request. For a forwarded read `rsp_rdata` is the region's `rgn_rdata`, and for writes it is zero.
- R4: A backup read returns the byte from `bk_rdata` times 0x01010101 for a word, times 0x0101 for a half, and zero-extended for a byte.
- R5: A backup access gets the raw request address on `rgn_addr`. On a write, `bk_wdata` carries `req_wdata` byte lane addr[1:0] for a word, lane addr[0] for a half, and lane 0 for a byte.
- R6: Writes to boot ROM or cartridge ROM are undefined, except the cases covered by R7.
- R7: A halfword write to 0x0800_00C4, 0x0800_00C6 or 0x0800_00C8 is ignored. Nothing is selected and no undefined indication is raised.
- R8: Byte writes to palette, video RAM or object memory are ignored. Nothing is selected and no indication is raised.
- R9: A byte write to 0x0400_0410 is ignored. Any other access there is undefined.
- R10: An access to an unmapped address selects nothing and returns zero. It pulses `undef_pulse` high for one cycle, aligned with `rsp_valid`.
- R11: `undef_sticky` is set with each `undef_pulse`. It holds until a cycle where `clear_undef` is high, and it clears in the following cycle. When a clear and a new undefined access fall in the same cycle, the flag stays set.
- R12: Size code 2'b11 is treated as an undefined access in every region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 reserved |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| clear_undef | input | 1 | Clears the sticky undefined flag |
| rgn_sel | output | 9 | One-hot region select |
| rgn_we | output | 1 | Write strobe to the selected region |
| rgn_size | output | 2 | Access size to the selected region |
| rgn_addr | output | 32 | Size-masked address (raw for backup) |
| rgn_wdata | output | 32 | Write data to word-wide regions |
| rgn_rdata | input | 32 | Read data from the selected word-wide region |
| bk_wdata | output | 8 | Lane-adapted write byte to backup |
| bk_rdata | input | 8 | Read byte from backup |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Registered read data |
| undef_pulse | output | 1 | One-cycle undefined-access indication |
| undef_sticky | output | 1 | Sticky undefined-access flag |

## Verification
Two events can land in the same cycle: a software clear of the sticky flag and a new undefined access that sets it again. The bench drives `clear_undef` in the same cycle as a request to an unmapped address. It expects the flag to read set in the next cycle. A later clear with no request must then bring the flag down. Apart from that case, the main sweep walks every region edge at four byte offsets, in all four sizes, for both reads and writes. Each observed port is compared against a map and policy that the bench computes from address ranges.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int NUM_RGN = 9;
    localparam int LANES   = DATA_W / 8;

    localparam logic [1:0] SZ_B = 2'b00;
    localparam logic [1:0] SZ_H = 2'b01;
    localparam logic [1:0] SZ_W = 2'b10;
    localparam logic [1:0] SZ_X = 2'b11;

    localparam logic [ADDR_W-1:0] PIN_A0     = 32'h0800_00C4;
    localparam logic [ADDR_W-1:0] PIN_A1     = 32'h0800_00C6;
    localparam logic [ADDR_W-1:0] PIN_A2     = 32'h0800_00C8;
    localparam logic [ADDR_W-1:0] QUIET_BYTE = 32'h0400_0410;

    typedef enum logic [3:0] {
        RG_BOOT = 4'd0,
        RG_XRAM = 4'd1,
        RG_IRAM = 4'd2,
        RG_IO   = 4'd3,
        RG_PAL  = 4'd4,
        RG_VRAM = 4'd5,
        RG_OAM  = 4'd6,
        RG_CART = 4'd7,
        RG_BKUP = 4'd8,
        RG_NONE = 4'd15
    } rgn_e;

    typedef enum logic [1:0] {
        AC_FWD    = 2'd0,
        AC_IGNORE = 2'd1,
        AC_UNDEF  = 2'd2
    } acc_e;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              valid;
        logic              undef;
        logic              sticky;
    } rsp_state_t;
endpackage

// File: rtl/hbus_region_map.sv
module hbus_region_map
    import hbus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rgn
);
    always_comb begin
        rgn = RG_NONE;
        case (addr[31:24])
            8'h00: if (addr[23:14] == 10'd0) rgn = RG_BOOT;
            8'h02: rgn = RG_XRAM;
            8'h03: rgn = RG_IRAM;
            8'h04: if (addr[23:10] == 14'd0 && addr[9:0] != 10'h3FF) rgn = RG_IO;
            8'h05: rgn = RG_PAL;
            8'h06: rgn = RG_VRAM;
            8'h07: rgn = RG_OAM;
            8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: rgn = RG_CART;
            8'h0E, 8'h0F: rgn = RG_BKUP;
            default: rgn = RG_NONE;
        endcase
    end
endmodule

// File: rtl/hbus_access_policy.sv
module hbus_access_policy
    import hbus_pkg::*;
(
    input  rgn_e              rgn,
    input  logic              wr,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output acc_e              acc
);
    logic pin_hit;
    assign pin_hit = (addr == PIN_A0) || (addr == PIN_A1) || (addr == PIN_A2);

    always_comb begin
        acc = AC_FWD;
        if (size == SZ_X) begin
            acc = AC_UNDEF;
        end else if (!wr) begin
            acc = (rgn == RG_NONE) ? AC_UNDEF : AC_FWD;
        end else begin
            case (rgn)
                RG_NONE: acc = (size == SZ_B && addr == QUIET_BYTE) ? AC_IGNORE : AC_UNDEF;
                RG_BOOT: acc = AC_UNDEF;
                RG_CART: acc = (size == SZ_H && pin_hit) ? AC_IGNORE : AC_UNDEF;
                RG_PAL, RG_VRAM, RG_OAM: acc = (size == SZ_B) ? AC_IGNORE : AC_FWD;
                default: acc = AC_FWD;
            endcase
        end
    end
endmodule

// File: rtl/hbus_backup_lane.sv
module hbus_backup_lane
    import hbus_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [1:0]       size,
    input  logic [1:0]       ofs,
    input  logic [WIDTH-1:0] wdata,
    input  logic [7:0]       rbyte,
    output logic [7:0]       wbyte,
    output logic [WIDTH-1:0] rword
);
    localparam int NL     = WIDTH / 8;
    localparam int LANE_W = (NL > 1) ? $clog2(NL) : 1;

    logic [7:0]        lane [NL];
    logic [LANE_W-1:0] pick;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam bit IN_HALF = (i < 2);
        localparam bit IS_LOW  = (i == 0);
        assign lane[i] = wdata[8*i +: 8];
        assign rword[8*i +: 8] =
            (IS_LOW || size == SZ_W || (size == SZ_H && IN_HALF)) ? rbyte : 8'h00;
    end

    always_comb begin
        case (size)
            SZ_W:    pick = LANE_W'(ofs);
            SZ_H:    pick = LANE_W'(ofs[0]);
            default: pick = '0;
        endcase
    end

    assign wbyte = lane[pick];
endmodule

// File: rtl/hbus_decoder.sv
module hbus_decoder
    import hbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               clear_undef,
    output logic [NUM_RGN-1:0] rgn_sel,
    output logic               rgn_we,
    output logic [1:0]         rgn_size,
    output logic [ADDR_W-1:0]  rgn_addr,
    output logic [DATA_W-1:0]  rgn_wdata,
    input  logic [DATA_W-1:0]  rgn_rdata,
    output logic [7:0]         bk_wdata,
    input  logic [7:0]         bk_rdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               undef_pulse,
    output logic               undef_sticky
);
    rgn_e              rgn;
    acc_e              acc;
    logic [DATA_W-1:0] bk_rword;
    logic              fwd;
    rsp_state_t        st_d, st_q;

    hbus_region_map u_map (
        .addr (req_addr),
        .rgn  (rgn)
    );

    hbus_access_policy u_policy (
        .rgn  (rgn),
        .wr   (req_write),
        .size (req_size),
        .addr (req_addr),
        .acc  (acc)
    );

    hbus_backup_lane #(.WIDTH(DATA_W)) u_bkup (
        .size  (req_size),
        .ofs   (req_addr[1:0]),
        .wdata (req_wdata),
        .rbyte (bk_rdata),
        .wbyte (bk_wdata),
        .rword (bk_rword)
    );

    assign fwd = req_valid && (acc == AC_FWD);

    // region-side outputs: select, strobe and size-masked address
    always_comb begin
        rgn_sel   = fwd ? (NUM_RGN'(1) << rgn) : '0;
        rgn_we    = fwd && req_write;
        rgn_size  = req_size;
        rgn_wdata = req_wdata;
        if (rgn == RG_BKUP) begin
            rgn_addr = req_addr;
        end else begin
            case (req_size)
                SZ_W:    rgn_addr = {req_addr[ADDR_W-1:2], 2'b00};
                SZ_H:    rgn_addr = {req_addr[ADDR_W-1:1], 1'b0};
                default: rgn_addr = req_addr;
            endcase
        end
    end

    // response state: next value
    always_comb begin
        st_d        = st_q;
        st_d.valid  = req_valid;
        st_d.undef  = req_valid && (acc == AC_UNDEF);
        st_d.sticky = (st_q.sticky && !clear_undef) || st_d.undef;
        st_d.rdata  = '0;
        if (fwd && !req_write) begin
            st_d.rdata = (rgn == RG_BKUP) ? bk_rword : rgn_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.valid;
    assign rsp_rdata    = st_q.rdata;
    assign undef_pulse  = st_q.undef;
    assign undef_sticky = st_q.sticky;
endmodule

// File: rtl/hbus_decoder_chk.sv
module hbus_decoder_chk
    import hbus_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [1:0]         req_size,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               clear_undef,
    input logic [NUM_RGN-1:0] rgn_sel,
    input logic               rgn_we,
    input logic [ADDR_W-1:0]  rgn_addr,
    input logic               rsp_valid,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic               undef_pulse,
    input logic               undef_sticky
);
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rgn_sel));

    p_word_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rgn_sel[7:0]) && req_size == SZ_W) |-> rgn_addr[1:0] == 2'b00);

    p_half_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rgn_sel[7:0]) && req_size == SZ_H) |-> !rgn_addr[0]);

    p_rsp_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !undef_pulse));

    p_bkup_raw_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rgn_sel[8] |-> rgn_addr == req_addr);

    p_rom_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rgn_we |-> (!rgn_sel[0] && !rgn_sel[7]));

    p_video_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn_we && req_size == SZ_B) |-> !(|rgn_sel[6:4]));

    p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        undef_pulse |-> rsp_rdata == '0);

    p_undef_nosel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn_sel != '0) |=> !undef_pulse);

    p_sticky_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        undef_pulse |-> undef_sticky);

    p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_sticky && !clear_undef) |=> undef_sticky);

    p_reserved_size_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == SZ_X) |-> rgn_sel == '0);
endmodule

bind hbus_decoder hbus_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_size     (req_size),
    .req_addr     (req_addr),
    .clear_undef  (clear_undef),
    .rgn_sel      (rgn_sel),
    .rgn_we       (rgn_we),
    .rgn_addr     (rgn_addr),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .undef_pulse  (undef_pulse),
    .undef_sticky (undef_sticky)
);

// File: tb/tb_hbus_decoder.sv
`timescale 1ns/1ps
module tb_hbus_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, clear_undef = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [8:0]  rgn_sel;
    logic        rgn_we;
    logic [1:0]  rgn_size;
    logic [31:0] rgn_addr, rgn_wdata, rgn_rdata;
    logic [7:0]  bk_wdata, bk_rdata;
    logic        rsp_valid, undef_pulse, undef_sticky;
    logic [31:0] rsp_rdata;

    int nvec = 0;
    int nfail = 0;
    bit sticky_m = 1'b0;

    always #2.5 clk = ~clk;

    // memory stand-ins: data is a fixed function of the address seen
    always_comb rgn_rdata = rgn_addr ^ 32'h5A5A_0000;
    always_comb bk_rdata  = rgn_addr[7:0] ^ 8'hC3;

    hbus_decoder dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .clear_undef(clear_undef), .rgn_sel(rgn_sel), .rgn_we(rgn_we),
        .rgn_size(rgn_size), .rgn_addr(rgn_addr), .rgn_wdata(rgn_wdata),
        .rgn_rdata(rgn_rdata), .bk_wdata(bk_wdata), .bk_rdata(bk_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .undef_pulse(undef_pulse), .undef_sticky(undef_sticky)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int exp_rgn(logic [31:0] a);
        if (a <= 32'h0000_3FFF) return 0;
        if (a >= 32'h0200_0000 && a <= 32'h02FF_FFFF) return 1;
        if (a >= 32'h0300_0000 && a <= 32'h03FF_FFFF) return 2;
        if (a >= 32'h0400_0000 && a <= 32'h0400_03FE) return 3;
        if (a >= 32'h0500_0000 && a <= 32'h05FF_FFFF) return 4;
        if (a >= 32'h0600_0000 && a <= 32'h06FF_FFFF) return 5;
        if (a >= 32'h0700_0000 && a <= 32'h07FF_FFFF) return 6;
        if (a >= 32'h0800_0000 && a <= 32'h0DFF_FFFF) return 7;
        if (a >= 32'h0E00_0000 && a <= 32'h0FFF_FFFF) return 8;
        return -1;
    endfunction

    // 0 forward, 1 ignore, 2 undefined
    function automatic int exp_cls(bit wr, logic [1:0] sz, logic [31:0] a);
        int r = exp_rgn(a);
        if (sz == 2'b11) return 2;
        if (!wr) return (r < 0) ? 2 : 0;
        if (r < 0) return (sz == 2'b00 && a == 32'h0400_0410) ? 1 : 2;
        if (r == 0) return 2;
        if (r == 7) return (sz == 2'b01 && (a == 32'h0800_00C4 || a == 32'h0800_00C6 ||
                            a == 32'h0800_00C8)) ? 1 : 2;
        if (r >= 4 && r <= 6) return (sz == 2'b00) ? 1 : 0;
        return 0;
    endfunction

    function automatic string req_tag(bit wr, logic [1:0] sz, int r, int c);
        if (sz == 2'b11) return "R12";
        if (r < 0) return (c == 1) ? "R9" : "R10";
        if (c == 2) return "R6";
        if (c == 1) return (r == 7) ? "R7" : "R8";
        if (r == 8) return wr ? "R5" : "R4";
        return "R1";
    endfunction

    task automatic access(bit wr, logic [1:0] sz, logic [31:0] a, logic [31:0] wd, bit clr);
        int r = exp_rgn(a);
        int c = exp_cls(wr, sz, a);
        string t = req_tag(wr, sz, r, c);
        logic [31:0] ea, erd;
        logic [8:0]  esel;
        logic [7:0]  eb;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_wdata = wd; clear_undef = clr;
        #1;
        esel = (c == 0) ? (9'd1 << r) : 9'd0;
        chk({t, " sel"}, 32'(rgn_sel), 32'(esel));
        chk({t, " we"}, 32'(rgn_we), 32'(wr && c == 0));
        if (c == 0) begin
            if (r == 8) ea = a;
            else if (sz == 2'b10) ea = a & 32'hFFFF_FFFC;
            else if (sz == 2'b01) ea = a & 32'hFFFF_FFFE;
            else ea = a;
            chk((r == 8) ? "R5 addr" : "R2 addr", rgn_addr, ea);
            chk("R1 size", 32'(rgn_size), 32'(sz));
            if (r == 8 && wr) begin
                if (sz == 2'b10) eb = 8'(wd >> (8 * a[1:0]));
                else if (sz == 2'b01) eb = 8'(wd[15:0] >> (8 * a[0]));
                else eb = wd[7:0];
                chk("R5 lane", 32'(bk_wdata), 32'(eb));
            end
        end else begin
            ea = a;
        end
        erd = 32'h0;
        if (c == 0 && !wr) begin
            if (r == 8) begin
                eb = ea[7:0] ^ 8'hC3;
                if (sz == 2'b10) erd = 32'(eb) * 32'h0101_0101;
                else if (sz == 2'b01) erd = 32'(eb) * 32'h0000_0101;
                else erd = 32'(eb);
            end else begin
                erd = ea ^ 32'h5A5A_0000;
            end
        end
        sticky_m = (sticky_m && !clr) || (c == 2);
        @(posedge clk);
        #1;
        chk("R3 valid", 32'(rsp_valid), 32'd1);
        chk((r == 8) ? "R4 rdata" : "R3 rdata", rsp_rdata, erd);
        chk({t, " undef"}, 32'(undef_pulse), 32'(c == 2));
        chk("R11 sticky", 32'(undef_sticky), 32'(sticky_m));
    endtask

    task automatic idle(bit clr);
        @(negedge clk);
        req_valid = 1'b0; clear_undef = clr;
        sticky_m = sticky_m && !clr;
        @(posedge clk);
        #1;
        chk("R3 idle valid", 32'(rsp_valid), 32'd0);
        chk("R10 idle pulse", 32'(undef_pulse), 32'd0);
        chk("R11 sticky idle", 32'(undef_sticky), 32'(sticky_m));
    endtask

    localparam logic [31:0] EDGES [35] = '{
        32'h0000_0000, 32'h0000_3FFF, 32'h0000_4000, 32'h01FF_FFFF, 32'h0200_0000,
        32'h02FF_FFFF, 32'h0300_0000, 32'h03FF_FFFF, 32'h0400_0000, 32'h0400_03FE,
        32'h0400_03FF, 32'h0400_0400, 32'h0400_0410, 32'h0500_0000, 32'h05FF_FFFF,
        32'h0600_0000, 32'h06FF_FFFF, 32'h0700_0000, 32'h07FF_FFFF, 32'h0800_0000,
        32'h0800_00C4, 32'h0800_00C5, 32'h0800_00C6, 32'h0800_00C8, 32'h0800_00CA,
        32'h09FF_FFFF, 32'h0A00_0000, 32'h0DFF_FFFF, 32'h0E00_0000, 32'h0E00_0001,
        32'h0E00_0002, 32'h0E00_0003, 32'h0FFF_FFFF, 32'h1000_0000, 32'hFFFF_FFFC
    };

    initial begin
        #1000000;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R3 reset valid", 32'(rsp_valid), 32'd0);
        chk("R3 reset rdata", rsp_rdata, 32'd0);
        chk("R10 reset pulse", 32'(undef_pulse), 32'd0);
        chk("R11 reset sticky", 32'(undef_sticky), 32'd0);
        chk("R1 reset sel", 32'(rgn_sel), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int e = 0; e < 35; e++)
            for (int o = 0; o < 4; o++)
                for (int s = 0; s < 4; s++)
                    for (int w = 0; w < 2; w++)
                        access(w[0], s[1:0], EDGES[e] + 32'(o),
                               32'hD4C3_B2A1 ^ {4{8'(o * 17 + s)}}, 1'b0);

        // R11: clear alone, then a clear colliding with a new undefined access
        idle(1'b1);
        chk("R11 cleared", 32'(undef_sticky), 32'd0);
        access(1'b0, 2'b10, 32'h1234_5678, 32'h0, 1'b1);
        chk("R11 set wins", 32'(undef_sticky), 32'd1);
        idle(1'b0);
        idle(1'b1);
        chk("R11 clear after hold", 32'(undef_sticky), 32'd0);
        idle(1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule